// File: doc/BRIEF.md
# Single-Wire Serial Master with Line Check

This block is a byte-wide serial master that talks over one shared open-drain data wire and generates the matching serial clock. Software programs a mode register, loads a byte into the data register and pulses a start strobe. The block then shifts eight bits out or in, least significant bit first, with the clock idle level and edge placement picked by a polarity bit and a phase bit.

Both pads are modelled as pull-low requests. A released pad reads high. When sending, the master reads back its own data line three times within every bit period and takes the 2-of-3 majority. If the majority of any bit disagrees with the bit that was driven, a failure flag is raised when the byte ends. The majority values are shifted back into the data register, so after a send it holds what the line actually carried.

In receive mode the data pad stays released and the far end drives the wire. A completion flag marks the end of every byte. Software clears it by writing to it, and it raises the interrupt line when interrupts are enabled.

Top module: `swspi_master`

## Requirements
- R1: Both pad outputs are pull-low requests (1 = pull low, 0 = release). While no transfer is running, `sdat_low_o` is 0.
- R2: While idle, the clock pad rests at the polarity bit: `sclk_low_o` equals the inverse of `mode_cpol_i` as last written. After reset the mode is all zero, so `sclk_low_o` is 1.
- R3: A bit lasts DIV system clocks, phases 0 to DIV-1. With phase bit 0, the clock sits at the idle level for phases below DIV/2 and at the opposite level from DIV/2 on. With phase bit 1 this is reversed.
- R4: In send mode (`mode_tx_i`=1), bit k of the data register is on the wire during the whole of bit period k, for k = 0 up to 7 (LSB first). `sdat_low_o` is the inverse of that bit.
- R5: A start accepted while idle is followed by `busy_o`=1 for exactly 8*DIV cycles. `done_o` rises in the cycle that `busy_o` falls, and not before.
- R6: In send mode the line is sampled at phases DIV/4, DIV/2 and 3*DIV/4 of each bit. A bit whose majority matches the driven value counts as good, even if one sample is disturbed. The majority value of each bit is shifted into the data register MSB end, so a clean send leaves the byte unchanged.
- R7: The failure flag is cleared when a transfer starts and holds during the transfer. At the end it is set if the majority of any bit differed from the bit driven.
- R8: In receive mode `sdat_low_o` stays 0. The line is captured at phase DIV/2 of each bit and assembled LSB first into the data register. The failure flag stays 0.
- R9: `done_o` stays set until a `done_clr_i` pulse. `irq_o` is `done_o` AND the interrupt-enable bit.
- R10: While busy, a start pulse or a data-register write has no effect: timing and the final data are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_wr_i | input | 1 | Write strobe for the mode register |
| mode_ie_i | input | 1 | Interrupt enable value to write |
| mode_tx_i | input | 1 | Direction to write (1 send, 0 receive) |
| mode_cpol_i | input | 1 | Clock polarity to write |
| mode_cpha_i | input | 1 | Clock phase to write |
| data_wr_i | input | 1 | Write strobe for the data register (idle only) |
| data_wdata_i | input | DW | Data register write value |
| start_i | input | 1 | Start strobe |
| done_clr_i | input | 1 | Write-to-clear for the completion flag |
| data_rdata_o | output | DW | Data register contents |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | Completion flag |
| fail_o | output | 1 | Transmission failure flag |
| irq_o | output | 1 | Interrupt request |
| sclk_low_o | output | 1 | Clock pad pull-low request |
| sdat_low_o | output | 1 | Data pad pull-low request |
| sdat_i | input | 1 | Sampled level of the data wire |

## Verification
The bench attacks the voting window. It disturbs one sample of a driven 1, which must not fail. It also disturbs two samples in two different pairings, which must fail and must clear the observed bit in the data register. A voter that used a single sample, or sampled at the wrong phase, would flag the first case or miss the second.

Each of the four polarity and phase settings is checked cycle by cycle against the expected clock level. A design with swapped edge placement would fail here. The bench also checks that a failed transfer followed by a clean one leaves the flag clear from the start, which catches a sticky flag.

A start pulse and a data write are issued mid-transfer. A design that restarted, or overwrote the byte, would finish late or return the wrong data.

// File: rtl/swspi_pkg.sv
// Shared types for the single-wire serial master.
// Assumes: nothing beyond IEEE 1800-2017.
package swspi_pkg;

    // Mode register contents.
    typedef struct packed {
        logic irq_en;
        logic tx;
        logic cpol;
        logic cpha;
    } swspi_mode_t;

endpackage

// File: rtl/swspi_bit_timer.sv
// Bit timer: counts system-clock phases within a bit period and bits within
// a byte. It flags the last phase of each bit and the last phase of the byte.
// Assumes: load and run are never both set; DIV >= 6.
module swspi_bit_timer #(
    parameter int DIV   = 8,
    parameter int NBITS = 8,
    localparam int PW   = $clog2(DIV),
    localparam int BW   = (NBITS > 1) ? $clog2(NBITS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic          run_i,
    output logic [PW-1:0] phase_o,
    output logic [BW-1:0] bit_o,
    output logic          bit_end_o,
    output logic          xfer_end_o
);

    logic [PW-1:0] phase_q;
    logic [BW-1:0] bit_q;
    logic          at_last_phase;

    // Detect the final phase of the current bit period.
    always_comb begin
        at_last_phase = (phase_q == PW'(DIV - 1));
    end

    // Advance the phase and bit counters while running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
            bit_q   <= '0;
        end else if (load_i) begin
            phase_q <= '0;
            bit_q   <= '0;
        end else if (run_i) begin
            if (at_last_phase) begin
                phase_q <= '0;
                bit_q   <= (bit_q == BW'(NBITS - 1)) ? '0 : bit_q + 1'b1;
            end else begin
                phase_q <= phase_q + 1'b1;
            end
        end
    end

    assign phase_o    = phase_q;
    assign bit_o      = bit_q;
    assign bit_end_o  = run_i && at_last_phase;
    assign xfer_end_o = run_i && at_last_phase && (bit_q == BW'(NBITS - 1));

    // R3: the phase never leaves the bit period.
    assert_phase_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        phase_q <= PW'(DIV - 1));

    // R5: a bit ends by stepping to phase 0 of the next bit.
    assert_bit_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && at_last_phase && bit_q != BW'(NBITS - 1) && !load_i)
        |=> (phase_q == '0) && (bit_q == BW'($past(bit_q) + 1'b1)));

endmodule

// File: rtl/swspi_vote.sv
// Majority voter: counts how many of the three read-back samples in a bit
// period saw a high line, and reports the 2-of-3 majority.
// Assumes: the sample phases lie below DIV-1, so the result is read on the
// last phase before the count is cleared (true for DIV >= 6).
module swspi_vote #(
    parameter int DIV  = 8,
    localparam int PW  = $clog2(DIV),
    localparam int NS  = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear_i,
    input  logic          run_i,
    input  logic [PW-1:0] phase_i,
    input  logic          line_i,
    output logic          maj_o
);

    logic [NS-1:0] hit;
    logic [1:0]    ones_q;

    // One compare per sample point, at quarter steps of the bit period.
    for (genvar g = 0; g < NS; g++) begin : g_pt
        assign hit[g] = (phase_i == PW'(((g + 1) * DIV) / 4));
    end

    // Count samples that read the line high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ones_q <= '0;
        end else if (clear_i) begin
            ones_q <= '0;
        end else if (run_i && (|hit) && line_i) begin
            ones_q <= ones_q + 1'b1;
        end
    end

    assign maj_o = (ones_q >= 2'd2);

    // R6: every bit period starts with an empty count.
    assert_vote_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (ones_q == 2'd0));

endmodule

// File: rtl/swspi_master.sv
// Single-wire serial master. It shifts one byte LSB first over an open-drain
// data wire with a generated clock. In send mode it checks each bit on the
// line by a 2-of-3 vote.
// Assumes: the mode is not rewritten during a transfer; sdat_i is already
// synchronous to clk; both pads are released-high open-drain.
module swspi_master
    import swspi_pkg::*;
#(
    parameter int DIV  = 8,
    parameter int DW   = 8,
    localparam int PW  = $clog2(DIV),
    localparam int BW  = (DW > 1) ? $clog2(DW) : 1,
    localparam int HALF = DIV / 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_wr_i,
    input  logic          mode_ie_i,
    input  logic          mode_tx_i,
    input  logic          mode_cpol_i,
    input  logic          mode_cpha_i,
    input  logic          data_wr_i,
    input  logic [DW-1:0] data_wdata_i,
    input  logic          start_i,
    input  logic          done_clr_i,
    output logic [DW-1:0] data_rdata_o,
    output logic          busy_o,
    output logic          done_o,
    output logic          fail_o,
    output logic          irq_o,
    output logic          sclk_low_o,
    output logic          sdat_low_o,
    input  logic          sdat_i
);

    swspi_mode_t   mode_q;
    logic [DW-1:0] shift_q;
    logic          busy_q, done_q, fail_q, fail_acc_q, cap_q;
    logic          start_go, bit_end, xfer_end, maj, bit_miss, in_bit;
    logic          clk_active, clk_level;
    logic [PW-1:0] phase_w;
    logic [BW-1:0] bit_w;

    assign start_go = start_i && !busy_q;

    swspi_bit_timer #(.DIV(DIV), .NBITS(DW)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (start_go),
        .run_i      (busy_q),
        .phase_o    (phase_w),
        .bit_o      (bit_w),
        .bit_end_o  (bit_end),
        .xfer_end_o (xfer_end)
    );

    swspi_vote #(.DIV(DIV)) u_vote (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (bit_end || start_go),
        .run_i   (busy_q),
        .phase_i (phase_w),
        .line_i  (sdat_i),
        .maj_o   (maj)
    );

    // Select the observed bit and detect a read-back mismatch.
    always_comb begin
        in_bit   = mode_q.tx ? maj : cap_q;
        bit_miss = bit_end && mode_q.tx && (maj != shift_q[0]);
    end

    // Mode register, written at any time.
    always_ff @(posedge clk) begin
        if (!rst_n)         mode_q <= '0;
        else if (mode_wr_i) mode_q <= '{irq_en: mode_ie_i, tx: mode_tx_i,
                                        cpol: mode_cpol_i, cpha: mode_cpha_i};
    end

    // Data register: host writes while idle, shift on each bit end.
    always_ff @(posedge clk) begin
        if (!rst_n)                      shift_q <= '0;
        else if (data_wr_i && !busy_q)   shift_q <= data_wdata_i;
        else if (bit_end)                shift_q <= {in_bit, shift_q[DW-1:1]};
    end

    // Receive capture at the mid-bit sampling edge.
    always_ff @(posedge clk) begin
        if (!rst_n)                                     cap_q <= 1'b0;
        else if (busy_q && phase_w == PW'(HALF))        cap_q <= sdat_i;
    end

    // Transfer state: busy, completion and failure flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q     <= 1'b0;
            done_q     <= 1'b0;
            fail_q     <= 1'b0;
            fail_acc_q <= 1'b0;
        end else begin
            if (start_go)      busy_q <= 1'b1;
            else if (xfer_end) busy_q <= 1'b0;

            if (xfer_end)        done_q <= 1'b1;
            else if (done_clr_i) done_q <= 1'b0;

            if (start_go)      fail_acc_q <= 1'b0;
            else if (bit_miss) fail_acc_q <= 1'b1;

            if (start_go)      fail_q <= 1'b0;
            else if (xfer_end) fail_q <= fail_acc_q || bit_miss;
        end
    end

    // Clock level from polarity and phase within the bit.
    always_comb begin
        clk_active = mode_q.cpha ? (phase_w < PW'(HALF)) : (phase_w >= PW'(HALF));
        clk_level  = mode_q.cpol ^ (busy_q && clk_active);
    end

    assign sclk_low_o   = !clk_level;
    assign sdat_low_o   = busy_q && mode_q.tx && !shift_q[0];
    assign data_rdata_o = shift_q;
    assign busy_o       = busy_q;
    assign done_o       = done_q;
    assign fail_o       = fail_q;
    assign irq_o        = done_q && mode_q.irq_en;

    // R1: the data pad is released whenever no transfer runs.
    assert_idle_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_q |-> !sdat_low_o);

    // R8: receive mode never pulls the data line.
    assert_rx_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !mode_q.tx) |-> !sdat_low_o);

    // R5: completion only follows the timer's end-of-byte.
    assert_done_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_q) |-> $past(xfer_end));

    // R7: the failure flag holds while bits are still moving.
    assert_fail_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !xfer_end) |=> $stable(fail_q));

    // R10: a start during a transfer does not rewind the timer.
    assert_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && start_i && phase_w != PW'(DIV - 1)) |=> (phase_w != '0));

endmodule

// File: tb/swspi_master_tb.sv
`timescale 1ns/1ps
// Directed bench for swspi_master: one task per scenario.
module swspi_master_tb;

    localparam int DIV = 8;
    localparam int DW  = 8;
    localparam int NCYC = DIV * DW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_wr = 0, mode_ie = 0, mode_tx = 0, mode_cpol = 0, mode_cpha = 0;
    logic data_wr = 0, start = 0, done_clr = 0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic busy, done, fail, irq, sclk_low, sdat_low;
    logic jam = 0, slave_low = 0;
    logic sdat_line;
    int checks = 0, failures = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    assign sdat_line = !(sdat_low || jam || slave_low);

    swspi_master #(.DIV(DIV), .DW(DW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .mode_wr_i(mode_wr), .mode_ie_i(mode_ie), .mode_tx_i(mode_tx),
        .mode_cpol_i(mode_cpol), .mode_cpha_i(mode_cpha),
        .data_wr_i(data_wr), .data_wdata_i(wdata), .start_i(start),
        .done_clr_i(done_clr), .data_rdata_o(rdata), .busy_o(busy),
        .done_o(done), .fail_o(fail), .irq_o(irq), .sclk_low_o(sclk_low),
        .sdat_low_o(sdat_low), .sdat_i(sdat_line)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // One full transfer with per-cycle checks; pokes start and a data write mid-way if asked.
    task automatic run_xfer(input logic tx, input logic cpol, input logic cpha,
                            input logic ie, input logic [DW-1:0] wbyte,
                            input logic [DW-1:0] slave, input int jam_bit,
                            input logic [2:0] jam_mask, input logic poke,
                            input logic exp_fail, input logic [DW-1:0] exp_data);
        int clk_err = 0, dat_err = 0, mid_fail = 0;
        mode_wr = 1; mode_tx = tx; mode_cpol = cpol; mode_cpha = cpha; mode_ie = ie;
        data_wr = 1; wdata = wbyte;
        @(negedge clk);
        mode_wr = 0; data_wr = 0;
        check(sclk_low == !cpol, "R2", "idle clock pad", sclk_low, !cpol);
        start = 1;
        @(negedge clk);
        start = 0;
        for (int i = 0; i < NCYC; i++) begin
            int k = i / DIV;
            int p = i % DIV;
            logic lvl;
            slave_low = !tx && !slave[k];
            jam = (k == jam_bit) && ((p == DIV/4 && jam_mask[0]) ||
                  (p == DIV/2 && jam_mask[1]) || (p == (3*DIV)/4 && jam_mask[2]));
            lvl = cpol ^ (cpha ? (p < DIV/2) : (p >= DIV/2));
            if (sclk_low != !lvl) clk_err++;
            if (tx ? (sdat_low != !wbyte[k]) : sdat_low) dat_err++;
            if (fail || !busy) mid_fail++;
            if (i == NCYC - 1) check(done == 0, "R5", "done before end", done, 0);
            if (poke && i == 20) begin
                start = 1; data_wr = 1; wdata = ~wbyte;
            end
            @(negedge clk);
            start = 0; data_wr = 0;
        end
        jam = 0; slave_low = 0;
        check(clk_err == 0, "R3", "clock level errors", clk_err, 0);
        check(dat_err == 0, tx ? "R4" : "R8", "data pad errors", dat_err, 0);
        check(mid_fail == 0, "R7", "mid-transfer fail/busy errors", mid_fail, 0);
        check(done == 1 && busy == 0, "R5", "done/busy at end", {done, busy}, 2'b10);
        check(fail == exp_fail, "R7", "fail flag", fail, exp_fail);
        check(rdata == exp_data, tx ? "R6" : "R8", "data register", rdata, exp_data);
        check(irq == ie, "R9", "irq gating", irq, ie);
        check(sdat_low == 0, "R1", "data released after", sdat_low, 0);
        done_clr = 1;
        @(negedge clk);
        done_clr = 0;
        check(done == 0 && irq == 0, "R9", "done cleared", {done, irq}, 0);
    endtask

    task automatic t_reset();
        check(done == 0 && fail == 0 && irq == 0 && busy == 0, "R5",
              "reset flags", {done, fail, irq, busy}, 0);
        check(sclk_low == 1, "R2", "reset clock pad", sclk_low, 1);
        check(sdat_low == 0, "R1", "reset data pad", sdat_low, 0);
        check(rdata == 0, "R8", "reset data", rdata, 0);
    endtask

    task automatic t_modes();
        run_xfer(1, 0, 0, 1, 8'hA5, 8'h00, -1, 3'b000, 0, 0, 8'hA5);
        run_xfer(1, 0, 1, 1, 8'h3C, 8'h00, -1, 3'b000, 0, 0, 8'h3C);
        run_xfer(1, 1, 0, 1, 8'h81, 8'h00, -1, 3'b000, 0, 0, 8'h81);
        run_xfer(1, 1, 1, 1, 8'h6E, 8'h00, -1, 3'b000, 0, 0, 8'h6E);
    endtask

    task automatic t_vote();
        run_xfer(1, 0, 0, 1, 8'hFF, 8'h00, 3, 3'b001, 0, 0, 8'hFF); // R6 single glitch
        run_xfer(1, 0, 0, 1, 8'hFF, 8'h00, 3, 3'b101, 0, 1, 8'hF7); // R6 two samples
        run_xfer(1, 1, 1, 1, 8'hF0, 8'h00, 6, 3'b110, 0, 1, 8'hB0); // R6 other pair
        run_xfer(1, 0, 0, 1, 8'hF0, 8'h00, -1, 3'b000, 0, 0, 8'hF0); // R7 cleared
    endtask

    task automatic t_rx();
        run_xfer(0, 0, 0, 1, 8'h00, 8'h96, -1, 3'b000, 0, 0, 8'h96);
        run_xfer(0, 1, 1, 1, 8'hFF, 8'h4B, -1, 3'b000, 0, 0, 8'h4B);
    endtask

    task automatic t_ignore();
        run_xfer(1, 0, 1, 0, 8'h5A, 8'h00, -1, 3'b000, 1, 0, 8'h5A); // R10
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_modes();
        t_vote();
        t_rx();
        t_ignore();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule